// File: doc/BRIEF.md
# Pointer-Based RAM Access Port

This block lets a host processor reach a 2K-byte buffer RAM through three small registers instead of a wide address bus. The host first loads an 11-bit byte pointer, upper bits first and lower byte second. It then moves bytes through a single data register. Writing the lower pointer byte starts a fetch from RAM into the data register. Every data-register access then advances the pointer. A read also fetches the next location, so sequential reads stream through the buffer with no further setup.

The port moves one byte per access in narrow mode and two bytes per access in wide mode. Width is chosen per access by a host input. In wide mode, host address bit 0 selects whether the two byte lanes are exchanged. In narrow mode, pointer bit 0 picks which half of the 16-bit RAM word reaches the host. The RAM side is a synchronous single-port memory organised as 1K words of 16 bits, with one write enable per byte lane. The even byte sits in bits 7:0 and the odd byte in bits 15:8. The upper-pointer register also holds a DMA enable bit, which the block only stores and presents on an output.

A fetch takes three cycles. After a strobe that starts a fetch, the host waits at least three cycles before its next data access.

Top module: `rap_host_port`

## Requirements
- R1: While reset is high, and after it is released, the pointer is 0, the DMA enable is 0 and `ram_en` is low. Reading either pointer register returns 0.
- R2: A write to address 3'b000 loads pointer bits 7:0 from `host_wdata[7:0]`. In the next cycle the block issues a RAM read (`ram_en`=1, `ram_we`=0) of word pointer[10:1]. A data read made three or more cycles after that write returns the fetched bytes.
- R3: A write to address 3'b001 does three things. It loads pointer bits 10:8 from `host_wdata[2:0]` and the DMA enable from `host_wdata[7]`. It leaves pointer bits 7:0 unchanged and issues no RAM access. The data register keeps its old contents. Reading 3'b001 returns {dma, 4'b0000, pointer[10:8]}.
- R4: In narrow mode (`host_wide`=0), a data read returns the byte at the pointer in `host_rdata[7:0]`, with `host_rdata[15:8]` = 0. A data write stores `host_wdata[7:0]` into that byte only, and the neighbouring byte is unchanged.
- R5: In wide mode, a data access covers the two bytes of word pointer[10:1]. With host address bit 0 = 0, host bits 7:0 are the even byte and bits 15:8 the odd byte. With bit 0 = 1, the lanes are exchanged. A wide write updates both bytes.
- R6: Each data-register access adds 1 to the pointer in narrow mode and 2 in wide mode. The pointer wraps modulo 2048, and the new value can be read back through the pointer registers.
- R7: A data read fetches the word at the advanced pointer. A data write starts no fetch: the data register keeps the word it last fetched.
- R8: Addresses 3'b100 and 3'b101 both select the data register. Writes to 3'b010, 3'b011, 3'b110 and 3'b111 change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register select; bit 0 is the lane swap for wide data accesses |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| host_rdata | output | 16 | Read data, valid during the read strobe cycle |
| dma_en | output | 1 | Stored DMA enable bit |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 2 | Byte-lane write enables (bit 0 even byte, bit 1 odd byte) |
| ram_addr | output | 10 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after the request |

## Verification
The bench reads the whole buffer twice, in narrow and in wide mode, with swap alternating across wide accesses. An increment or lane-select fault therefore shows up as a shifted or swapped byte, and a faulty wrap shows up at the last address.

Writes are checked by reading the region back, including the bytes on either side. This exposes a wrong lane enable, which would corrupt a neighbour.

Two staleness cases need care. One is a write that wrongly refreshes the data register. The other is an upper-pointer write that wrongly starts a fetch. In both, the bench expects the old word, and a design with either fault returns the new one. Decoding of the unused addresses is checked by confirming the pointer is unchanged afterwards.

// File: rtl/rap_pkg.sv
package rap_pkg;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_DATA = 2'd3
    } reg_sel_e;

    localparam logic [2:0] ADR_PLO    = 3'b000;
    localparam logic [2:0] ADR_PHI    = 3'b001;
    localparam logic [1:0] ADR_DATA_U = 2'b10;

    function automatic reg_sel_e decode_sel(input logic [2:0] a);
        if (a == ADR_PLO)              return SEL_PLO;
        else if (a == ADR_PHI)         return SEL_PHI;
        else if (a[2:1] == ADR_DATA_U) return SEL_DATA;
        else                           return SEL_NONE;
    endfunction

    function automatic logic [15:0] lane_swap(input logic [15:0] w, input logic s);
        return s ? {w[7:0], w[15:8]} : w;
    endfunction

    function automatic logic [1:0] lane_mask(input logic wide, input logic odd);
        if (wide) return 2'b11;
        return odd ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/rap_ptr.sv
module rap_ptr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic              step_en,
    input  logic              wide,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-9:0] hi_in,
    input  logic              dma_in,
    output logic [ADDR_W-1:0] ptr,
    output logic              dma_en
);
    logic [ADDR_W-1:0] step;

    always_comb step = wide ? ADDR_W'(2) : ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr    <= '0;
            dma_en <= 1'b0;
        end else if (lo_wr) begin
            ptr[7:0] <= byte_in;
        end else if (hi_wr) begin
            ptr[ADDR_W-1:8] <= hi_in;
            dma_en          <= dma_in;
        end else if (step_en) begin
            ptr <= ptr + step;
        end
    end

    // R6: data accesses advance the pointer by the access width
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (step_en && !lo_wr && !hi_wr) |=> (ptr == $past(ptr) + $past(step)));

    // R3: upper-byte write keeps the low pointer byte
    p_hi_keeps_low_r3: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (ptr[7:0] == $past(ptr[7:0])));

endmodule

// File: rtl/rap_ramseq.sv
module rap_ramseq import rap_pkg::*; #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              wide,
    input  logic              swap,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [15:0]       wdata,
    output logic              ram_en,
    output logic [1:0]        ram_we,
    output logic [ADDR_W-2:0] ram_addr,
    output logic [15:0]       ram_wdata,
    output logic              cap
);
    logic fetch_q;
    logic cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_q <= 1'b0;
            cap_q   <= 1'b0;
        end else begin
            fetch_q <= lo_wr | data_rd;
            cap_q   <= fetch_q & ~data_wr;
        end
    end

    always_comb begin
        ram_addr  = ptr[ADDR_W-1:1];
        ram_en    = data_wr | fetch_q;
        ram_we    = data_wr ? lane_mask(wide, ptr[0]) : 2'b00;
        ram_wdata = wide ? lane_swap(wdata, swap) : {wdata[7:0], wdata[7:0]};
    end

    assign cap = cap_q;

    // R2: the data register only loads after a RAM read cycle
    p_cap_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        cap_q |-> ($past(ram_en) && $past(ram_we) == 2'b00));

    // R4: a narrow write touches exactly one byte lane
    p_narrow_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !wide) |-> ($countones(ram_we) == 1));

    // R5: a wide write touches both byte lanes
    p_wide_lanes_r5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && wide) |-> (ram_we == 2'b11));

endmodule

// File: rtl/rap_dreg.sv
module rap_dreg import rap_pkg::*; (
    input  logic        clk,
    input  logic        cap,
    input  logic [15:0] ram_rdata,
    input  logic        wide,
    input  logic        swap,
    input  logic        lane,
    output logic [15:0] rd_word
);
    logic [15:0] dreg_q;

    always_ff @(posedge clk) begin
        if (cap) dreg_q <= ram_rdata;
    end

    always_comb begin
        if (wide) rd_word = lane_swap(dreg_q, swap);
        else      rd_word = {8'h00, lane ? dreg_q[15:8] : dreg_q[7:0]};
    end

endmodule

// File: rtl/rap_host_port.sv
module rap_host_port import rap_pkg::*; #(
    parameter int ADDR_W  = 11,
    parameter int DMA_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        host_addr,
    input  logic [15:0]       host_wdata,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_wide,
    output logic [15:0]       host_rdata,
    output logic              dma_en,
    output logic              ram_en,
    output logic [1:0]        ram_we,
    output logic [ADDR_W-2:0] ram_addr,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata
);
    localparam int HI_W = ADDR_W - 8;

    reg_sel_e          sel;
    logic              lo_wr, hi_wr, data_rd, data_wr, step_en, swap, cap;
    logic [ADDR_W-1:0] ptr;
    logic [15:0]       rd_word;
    logic [7:0]        hi_view;

    always_comb begin
        sel     = decode_sel(host_addr);
        lo_wr   = host_wr && (sel == SEL_PLO);
        hi_wr   = host_wr && (sel == SEL_PHI);
        data_rd = host_rd && (sel == SEL_DATA);
        data_wr = host_wr && (sel == SEL_DATA);
        step_en = data_rd || data_wr;
        swap    = host_wide & host_addr[0];
    end

    rap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .step_en (step_en),
        .wide    (host_wide),
        .byte_in (host_wdata[7:0]),
        .hi_in   (host_wdata[HI_W-1:0]),
        .dma_in  (host_wdata[DMA_BIT]),
        .ptr     (ptr),
        .dma_en  (dma_en)
    );

    rap_ramseq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .lo_wr     (lo_wr),
        .data_rd   (data_rd),
        .data_wr   (data_wr),
        .wide      (host_wide),
        .swap      (swap),
        .ptr       (ptr),
        .wdata     (host_wdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .cap       (cap)
    );

    rap_dreg u_dreg (
        .clk       (clk),
        .cap       (cap),
        .ram_rdata (ram_rdata),
        .wide      (host_wide),
        .swap      (swap),
        .lane      (ptr[0]),
        .rd_word   (rd_word)
    );

    always_comb begin
        hi_view                = '0;
        hi_view[HI_W-1:0]      = ptr[ADDR_W-1:8];
        hi_view[DMA_BIT]       = dma_en;
        case (sel)
            SEL_PLO:  host_rdata = {8'h00, ptr[7:0]};
            SEL_PHI:  host_rdata = {8'h00, hi_view};
            SEL_DATA: host_rdata = rd_word;
            default:  host_rdata = 16'h0000;
        endcase
    end

    // R2: low-pointer write is followed by a RAM access
    p_lo_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> ram_en);

    // R3: upper-pointer write starts no fetch
    p_hi_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (ram_en == (host_wr && decode_sel(host_addr) == SEL_DATA)));

    // R8: unused addresses leave pointer and DMA bit alone
    p_bad_addr_r8: assert property (@(posedge clk) disable iff (rst)
        ((host_wr || host_rd) && sel == SEL_NONE) |=> ($stable(ptr) && $stable(dma_en)));

endmodule

// File: tb/rap_host_port_tb.sv
`timescale 1ns/1ps
module rap_host_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_wide = 1'b0;
    logic [15:0] host_rdata;
    logic        dma_en;
    logic        ram_en;
    logic [1:0]  ram_we;
    logic [9:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;

    int n_checks = 0;
    int n_err    = 0;
    logic en_after;

    logic [15:0] mem   [1024];
    logic [7:0]  ref_b [2048];

    always #4 clk = ~clk;

    rap_host_port dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_wide(host_wide),
        .host_rdata(host_rdata), .dma_en(dma_en), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
            if (ram_we[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
            ram_rdata <= mem[ram_addr];
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29) + (i >> 8) * 7 + 3);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] a, input logic [15:0] d, input logic wr,
                          input logic wide, output logic [15:0] rdv);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = wr; host_rd = !wr; host_wide = wide;
        #1 rdv = host_rdata;
        @(negedge clk);
        en_after = ram_en;
        host_wr = 1'b0; host_rd = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        logic [15:0] dummy;
        strobe(a, d, 1'b1, 1'b0, dummy);
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
        strobe(a, 16'h0, 1'b0, 1'b0, v);
    endtask

    task automatic set_ptr(input int p);
        wr_reg(3'b001, 16'((p >> 8) & 7));
        wr_reg(3'b000, 16'(p & 255));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  old;
        for (int i = 0; i < 1024; i++) mem[i] = {pat(2 * i + 1), pat(2 * i)};
        for (int i = 0; i < 2048; i++) ref_b[i] = pat(i);

        // R1 reset state
        repeat (4) @(negedge clk);
        check("R1 ram_en in reset", {15'h0, ram_en}, 16'h0);
        check("R1 dma_en in reset", {15'h0, dma_en}, 16'h0);
        rst = 1'b0;
        rd_reg(3'b000, v); check("R1 ptr low after reset", v, 16'h0000);
        rd_reg(3'b001, v); check("R1 ptr high after reset", v, 16'h0000);

        // R3 upper write: no fetch, dma bit, readback
        wr_reg(3'b001, 16'h0085);
        check("R3 no RAM access after high write", {15'h0, en_after}, 16'h0);
        check("R3 dma_en set", {15'h0, dma_en}, 16'h1);
        rd_reg(3'b001, v); check("R3 high readback", v, 16'h0085);
        rd_reg(3'b000, v); check("R3 low byte kept", v, 16'h0000);

        // R2 low write fetches
        wr_reg(3'b000, 16'h0000);
        check("R2 RAM read after low write", {15'h0, en_after}, 16'h1);
        strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
        check("R2 first fetched byte", v, {8'h00, ref_b[12'h500]});

        // R4 R6 narrow sweep with wrap
        set_ptr(0);
        for (int i = 0; i < 2050; i++) begin
            strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
            check("R4 narrow read", v, {8'h00, ref_b[i % 2048]});
        end
        rd_reg(3'b000, v); check("R6 low after wrap", v, 16'h0002);
        rd_reg(3'b001, v); check("R6 high after wrap", v, 16'h0000);

        // R5 R6 wide sweep, swap alternating
        set_ptr(0);
        for (int w = 0; w < 1025; w++) begin
            logic a0;
            a0 = 1'(w % 2);
            strobe({2'b10, a0}, 16'h0, 1'b0, 1'b1, v);
            if (a0) check("R5 wide read swapped", v,
                          {ref_b[(2 * w) % 2048], ref_b[(2 * w + 1) % 2048]});
            else    check("R5 wide read", v,
                          {ref_b[(2 * w + 1) % 2048], ref_b[(2 * w) % 2048]});
        end
        set_ptr(12'h123);
        strobe(3'b100, 16'h0, 1'b0, 1'b1, v);
        check("R5 wide read odd pointer", v, {ref_b[12'h123], ref_b[12'h122]});
        rd_reg(3'b000, v); check("R6 wide step of 2", v, 16'h0025);

        // R4 narrow writes with neighbours
        set_ptr(12'h200);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            b = 8'((i * 53) + 11);
            strobe(3'b100, {8'hEE, b}, 1'b1, 1'b0, v);
            ref_b[12'h200 + i] = b;
        end
        set_ptr(12'h1FE);
        for (int i = 0; i < 20; i++) begin
            strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
            check("R4 narrow write readback", v, {8'h00, ref_b[12'h1FE + i]});
        end

        // R5 wide writes, swap alternating
        set_ptr(12'h300);
        for (int w = 0; w < 8; w++) begin
            logic [15:0] d;
            logic        a0;
            d  = 16'((w * 4097) + 16'h1357);
            a0 = 1'(w % 2);
            strobe({2'b10, a0}, d, 1'b1, 1'b1, v);
            if (a0) begin
                ref_b[12'h300 + 2 * w]     = d[15:8];
                ref_b[12'h300 + 2 * w + 1] = d[7:0];
            end else begin
                ref_b[12'h300 + 2 * w]     = d[7:0];
                ref_b[12'h300 + 2 * w + 1] = d[15:8];
            end
        end
        set_ptr(12'h2FF);
        for (int i = 0; i < 18; i++) begin
            strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
            check("R5 wide write readback", v, {8'h00, ref_b[12'h2FF + i]});
        end

        // R7 writes do not refresh the data register, reads do
        set_ptr(12'h400);
        old = ref_b[12'h400];
        strobe(3'b100, 16'h00A5, 1'b1, 1'b0, v);
        strobe(3'b100, 16'h005A, 1'b1, 1'b0, v);
        ref_b[12'h400] = 8'hA5; ref_b[12'h401] = 8'h5A;
        strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
        check("R7 stale word after writes", v, {8'h00, old});
        strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
        check("R7 prefetch after read", v, {8'h00, ref_b[12'h403]});

        // R3 high write alone does not reload the data register
        set_ptr(12'h010);
        wr_reg(3'b001, 16'h0003);
        strobe(3'b100, 16'h0, 1'b0, 1'b0, v);
        check("R3 data register not reloaded", v, {8'h00, ref_b[12'h010]});

        // R8 unused addresses and data alias
        set_ptr(12'h055);
        wr_reg(3'b010, 16'hFFFF);
        check("R8 no RAM access on unused write", {15'h0, en_after}, 16'h0);
        wr_reg(3'b011, 16'hFFFF);
        wr_reg(3'b110, 16'hFFFF);
        wr_reg(3'b111, 16'hFFFF);
        rd_reg(3'b000, v); check("R8 low pointer unchanged", v, 16'h0055);
        rd_reg(3'b001, v); check("R8 high pointer unchanged", v, 16'h0000);
        rd_reg(3'b010, v); check("R8 unused read is zero", v, 16'h0000);
        rd_reg(3'b111, v); check("R8 unused read is zero", v, 16'h0000);
        strobe(3'b101, 16'h0, 1'b0, 1'b0, v);
        check("R8 data alias at 3'b101", v, {8'h00, ref_b[12'h055]});

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule